// File: doc/BRIEF.md
# FIFO Controller with Read Rewind

A single-clock first-in/first-out buffer for 9-bit words. A 9-bit word lets a parity or control bit travel beside eight data bits. A write-request strobe stores the word on `wr_data` at the next free location. A read-request strobe fetches the oldest stored word. The fetched word appears on `rd_data`, and `rd_valid` is high for one cycle to mark it. The read and write positions are ring pointers into an internal array, whose depth is a parameter that must be a power of two. No address is ever presented at the interface.

Three active-low flags report the state of the buffer: `empty_n`, `full_n` and `half_n`. A request that the flags forbid is refused, and its pointer stays where it is.

A rewind input, `rt_n`, sends the read pointer back to location zero and leaves the write pointer alone. Everything written since the last reset can then be read again. This holds as long as no more than the buffer depth has been written since that reset.

A read requested while the buffer is empty is held. It is served automatically as soon as a word arrives, so a consumer that is already waiting gets the first word without asking again.

Top module: `fifo_rt_ctrl`

## Requirements
- R1: Words are 9 bits wide, all 9 bits are stored, and words are returned in the order they were written.
- R2: While `rst_n` is low, and after it is released, both pointers are at location zero, `empty_n` is 0, `full_n` is 1, `half_n` is 1 and `rd_valid` is 0.
- R3: A write request made while `full_n` is 0 is refused. The word is not stored and the write pointer does not move.
- R4: A read request made while `empty_n` is 0 performs no read: `rd_valid` stays 0 and the read pointer does not move.
- R5: Starting from reset, with no reads, `full_n` goes to 0 at the clock edge of the DEPTH-th write and not before. It returns to 1 at the edge of the next read.
- R6: `half_n` is 0 exactly when more than DEPTH/2 words are held. It falls at the edge of the write that crosses that level and rises at the edge of the read that brings the count to DEPTH/2 or fewer.
- R7: A cycle with both a valid read and a valid write leaves the word count unchanged, so `half_n` and `full_n` do not toggle.
- R8: A cycle with `rt_n` low sets the read pointer to zero and keeps the write pointer. All three flags are then recomputed from the number of words written since reset, and reads replay from the first word.
- R9: Read and write requests made while `rst_n` or `rt_n` is low are ignored, and `rd_valid` is 0 in the cycle after such a rewind cycle.
- R10: If a read is requested while the buffer is empty, the first word later written is delivered on `rd_data` with `rd_valid` high one cycle after `empty_n` rises, without a further request.
- R11: The word read in a valid read cycle is on `rd_data` with `rd_valid` high after that cycle's clock edge, and `rd_valid` is 0 after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| wr_req | input | 1 | Write request for the current cycle |
| wr_data | input | 9 | Word to store |
| rd_req | input | 1 | Read request for the current cycle |
| rt_n | input | 1 | Active-low rewind of the read pointer |
| rd_data | output | 9 | Last word read |
| rd_valid | output | 1 | High for one cycle when `rd_data` holds a new word |
| empty_n | output | 1 | Low when no words are held |
| full_n | output | 1 | Low when DEPTH words are held |
| half_n | output | 1 | Low when more than DEPTH/2 words are held |

## Verification
The bench fills the buffer to the last slot and writes once more. A design that lets the extra write through would overwrite the oldest word, or would return DEPTH+1 words when drained.

It crosses the half-depth level with a single write and then with a single read. It also runs a simultaneous read and write at exactly DEPTH/2+1 words held. An off-by-one threshold, or a counter that moves on a combined access, shows up as `half_n` in the wrong state after the next single read.

The rewind is exercised three ways:
- while read and write requests are held high, where a leak would add a word or produce a spurious `rd_valid`;
- after a complete fill, where occupancy taken from the wrapped write pointer must bring `full_n` back low;
- in the ordinary replay case.

A read requested on an empty buffer must not pulse `rd_valid` at once, and must deliver the next written word without a second request.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
    localparam int WORD_W = 9;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];
endmodule

// File: rtl/fifo_rt_ptrs.sv
module fifo_rt_ptrs #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          rd_go,
    input  logic          rt_n,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n
);
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [PW-1:0] cnt;
        logic          empty_n;
        logic          full_n;
        logic          half_n;
    } ptr_st_t;

    ptr_st_t st_d, st_q;
    logic    rd_en;

    always_comb begin
        st_d  = st_q;
        wr_en = wr_req && st_q.full_n && rt_n;
        rd_en = rd_go && st_q.empty_n && rt_n;
        if (!rt_n) begin
            st_d.rd  = '0;
            st_d.cnt = st_q.wr;
        end else begin
            if (wr_en) st_d.wr = st_q.wr + 1'b1;
            if (rd_en) st_d.rd = st_q.rd + 1'b1;
            case ({wr_en, rd_en})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
        st_d.empty_n = (st_d.cnt != '0);
        st_d.full_n  = (st_d.cnt != FULL_CNT);
        st_d.half_n  = !(st_d.cnt > HALF_CNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wr: '0, rd: '0, cnt: '0, empty_n: 1'b0, full_n: 1'b1, half_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_addr = st_q.wr[AW-1:0];
    assign rd_addr = st_q.rd[AW-1:0];
    assign empty_n = st_q.empty_n;
    assign full_n  = st_q.full_n;
    assign half_n  = st_q.half_n;

    // R3: a refused write leaves the write pointer in place
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.full_n && wr_req) |=> $stable(st_q.wr));

    // R4: a read on an empty buffer leaves the read pointer in place
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.empty_n && rt_n) |=> $stable(st_q.rd));

    // R8: rewind sends the read pointer home and keeps the write pointer
    a_r8_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        !rt_n |=> (st_q.rd == '0) && $stable(st_q.wr));

    // R7: a combined read and write keeps the occupancy
    a_r7_combined_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en) |=> $stable(st_q.cnt));

    // R2: empty and full are never reported together
    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.empty_n || st_q.full_n);
endmodule

// File: rtl/fifo_rt_rdport.sv
module fifo_rt_rdport
    import fifo_rt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rd_req,
    input  logic  rt_n,
    input  logic  empty_n,
    input  word_t mem_rdata,
    output logic  rd_go,
    output word_t rd_data,
    output logic  rd_valid
);
    typedef struct packed {
        word_t data;
        logic  valid;
        logic  pend;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        rd_go = (rd_req || st_q.pend) && empty_n && rt_n;
        st_d.valid = rd_go;
        if (rd_go) st_d.data = mem_rdata;
        if (!rt_n) begin
            st_d.pend = 1'b0;
        end else begin
            st_d.pend = (st_q.pend || rd_req) && !rd_go;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{data: '0, valid: 1'b0, pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.data;
    assign rd_valid = st_q.valid;

    // R11: a valid pulse only follows a read cycle
    a_r11_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> $past(rd_go));

    // R9: no word is delivered after a rewind cycle
    a_r9_rewind_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rt_n |=> !st_q.valid);

    // R4: nothing is read while the buffer is empty
    a_r4_no_read_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |=> !st_q.valid);
endmodule

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_req,
    input  logic [8:0] wr_data,
    input  logic       rd_req,
    input  logic       rt_n,
    output logic [8:0] rd_data,
    output logic       rd_valid,
    output logic       empty_n,
    output logic       full_n,
    output logic       half_n
);
    localparam int AW = $clog2(DEPTH);

    logic          wr_en;
    logic          rd_go;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    word_t         mem_rdata;
    logic          empty_n_w;

    fifo_rt_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_req),
        .rd_go   (rd_go),
        .rt_n    (rt_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .empty_n (empty_n_w),
        .full_n  (full_n),
        .half_n  (half_n)
    );

    fifo_rt_mem #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (mem_rdata)
    );

    fifo_rt_rdport u_rdport (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rt_n      (rt_n),
        .empty_n   (empty_n_w),
        .mem_rdata (mem_rdata),
        .rd_go     (rd_go),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    assign empty_n = empty_n_w;
endmodule

// File: tb/test_fifo_rt_ctrl.sv
module test_fifo_rt_ctrl;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_req = 1'b0;
    logic [8:0] wr_data = '0;
    logic       rd_req = 1'b0;
    logic       rt_n = 1'b1;
    logic [8:0] rd_data;
    logic       rd_valid, empty_n, full_n, half_n;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    fifo_rt_ctrl #(.DEPTH(DEPTH)) i_fifo_rt_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data),
        .rd_req(rd_req), .rt_n(rt_n), .rd_data(rd_data), .rd_valid(rd_valid),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic [8:0] d, input logic r, input logic t);
        wr_req = w; wr_data = d; rd_req = r; rt_n = t;
        @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b0; rt_n = 1'b1;
    endtask

    task automatic wr(input logic [8:0] d);
        cyc(1'b1, d, 1'b0, 1'b1);
    endtask

    task automatic rd_expect(input string tag, input logic [8:0] exp);
        cyc(1'b0, '0, 1'b1, 1'b1);
        chk({tag, " valid"}, int'(rd_valid), 1);
        chk({tag, " data"}, int'(rd_data), int'(exp));
    endtask

    task automatic do_reset;
        rst_n = 1'b0; wr_req = 1'b1; rd_req = 1'b1; wr_data = 9'h1FF;
        @(negedge clk); @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b0; rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        do_reset();
        chk("R2 empty_n", int'(empty_n), 0);
        chk("R2 full_n", int'(full_n), 1);
        chk("R2 half_n", int'(half_n), 1);
        chk("R2 rd_valid", int'(rd_valid), 0);
        chk("R9 no write during reset", int'(empty_n), 0);
    endtask

    task automatic t_order;
        do_reset();
        for (int i = 0; i < 5; i++) wr(9'(9'h0A5 + i * 9'h049));
        for (int i = 0; i < 5; i++) rd_expect("R1 order", 9'(9'h0A5 + i * 9'h049));
        cyc(1'b0, '0, 1'b0, 1'b1);
        chk("R11 valid drops", int'(rd_valid), 0);
        chk("R1 empty after drain", int'(empty_n), 0);
    endtask

    task automatic t_full;
        do_reset();
        for (int i = 0; i < DEPTH - 1; i++) wr(9'(9'h100 | i));
        chk("R5 not full early", int'(full_n), 1);
        wr(9'(9'h100 | (DEPTH - 1)));
        chk("R5 full at DEPTH", int'(full_n), 0);
        chk("R6 half at DEPTH", int'(half_n), 0);
        wr(9'h0AA);
        chk("R3 still full", int'(full_n), 0);
        rd_expect("R3 oldest kept", 9'h100);
        chk("R5 full clears on read", int'(full_n), 1);
        for (int i = 1; i < DEPTH; i++) rd_expect("R3 drain", 9'(9'h100 | i));
        chk("R3 no extra word", int'(empty_n), 0);
    endtask

    task automatic t_half;
        do_reset();
        for (int i = 0; i < DEPTH / 2; i++) wr(9'(i));
        chk("R6 half at DEPTH/2", int'(half_n), 1);
        wr(9'h033);
        chk("R6 over half", int'(half_n), 0);
        rd_expect("R6 read", 9'h000);
        chk("R6 back to half", int'(half_n), 1);
    endtask

    task automatic t_empty_read;
        do_reset();
        cyc(1'b0, '0, 1'b1, 1'b1);
        chk("R4 no valid on empty", int'(rd_valid), 0);
        chk("R4 still empty", int'(empty_n), 0);
        do_reset();
    endtask

    task automatic t_combined;
        do_reset();
        for (int i = 0; i < DEPTH / 2 + 1; i++) wr(9'(9'h040 + i));
        chk("R7 over half before", int'(half_n), 0);
        cyc(1'b1, 9'h1C3, 1'b1, 1'b1);
        chk("R7 read data", int'(rd_data), 9'h040);
        chk("R7 half steady", int'(half_n), 0);
        chk("R7 full steady", int'(full_n), 1);
        rd_expect("R7 next read", 9'h041);
        chk("R7 count unchanged", int'(half_n), 1);
    endtask

    task automatic t_rewind;
        do_reset();
        for (int i = 0; i < 4; i++) wr(9'(9'h1E0 + i));
        rd_expect("R8 pre", 9'h1E0);
        rd_expect("R8 pre", 9'h1E1);
        cyc(1'b1, 9'h155, 1'b1, 1'b0);
        chk("R9 no read in rewind", int'(rd_valid), 0);
        chk("R8 not empty", int'(empty_n), 1);
        chk("R8 half", int'(half_n), 1);
        for (int i = 0; i < 4; i++) rd_expect("R8 replay", 9'(9'h1E0 + i));
        chk("R9 no write in rewind", int'(empty_n), 0);
    endtask

    task automatic t_rewind_full;
        do_reset();
        for (int i = 0; i < DEPTH; i++) wr(9'(9'h080 + i));
        for (int i = 0; i < 3; i++) rd_expect("R8 pre", 9'(9'h080 + i));
        chk("R8 not full before", int'(full_n), 1);
        cyc(1'b0, '0, 1'b0, 1'b0);
        chk("R8 full after rewind", int'(full_n), 0);
        rd_expect("R8 first again", 9'h080);
    endtask

    task automatic t_flow;
        do_reset();
        cyc(1'b0, '0, 1'b1, 1'b1);
        chk("R10 no valid yet", int'(rd_valid), 0);
        wr(9'h16D);
        chk("R10 empty cleared", int'(empty_n), 1);
        chk("R10 not yet", int'(rd_valid), 0);
        cyc(1'b0, '0, 1'b0, 1'b1);
        chk("R10 delivered", int'(rd_valid), 1);
        chk("R10 data", int'(rd_data), 9'h16D);
        chk("R10 empty again", int'(empty_n), 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_order();
        t_full();
        t_half();
        t_empty_read();
        t_combined();
        t_rewind();
        t_rewind_full();
        t_flow();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule